// File: doc/BRIEF.md
# Chip Reset Sequencer with Cause Capture

This block produces the chip-wide reset. Three events can start a reset: the board-level reset pin going low, software setting a request bit, and an overflow pulse from the watchdog. The pin is synchronized and then passes through a minimum-width filter, so glitches and short dips are ignored. The block keeps the chip in reset while any event is still active. After that it waits for the PLL to report lock. Only then is the main reset released, synchronously to the reference clock.

A small register file gives software three views. The first is the software request bit, which clears itself. The second is a record of which events caused the most recent reset. The third is the synchronized PLL lock state, together with a sticky flag that sets when lock takes longer than the allowed window. These registers are reset only by power-on, so the cause record survives the chip reset it describes. Software clears cause bits by writing ones to them. A second reset output serves a subsystem that must never be reset by any of the three events. It follows power-on alone.

Time limits are given in microseconds together with the clock frequency in MHz. The cycle counts are derived from these parameters.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` and `iso_rst_n` are low. After power-on, the cause register (address 1) and the PLL register (address 2) read 0 until an event occurs.
- R2: After every event has ended, `sys_rst_n` stays low until the synchronized `pll_lock` is high. It is then released on a clock edge.
- R3: `ext_rst_n` held low for at least PIN_MIN_US×CLK_MHZ cycles, measured after a two-flop synchronizer, starts a reset. A shorter low pulse has no effect on `sys_rst_n` or on the cause register.
- R4: Writing 1 to bit 0 of the control register (address 0) starts a reset. The bit reads 1 while pending, clears itself once the reset begins, and a write made while the chip is in reset is discarded.
- R5: `wdog_ovf` high for one clock cycle starts a reset.
- R6: Cause register bit 0 records the pin, bit 1 software and bit 2 the watchdog. The bits are not cleared by the chip reset. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R7: When several events overlap, every matching cause bit is set. `sys_rst_n` stays low until the last of them has ended.
- R8: `iso_rst_n` depends only on `por_n`. It is released two clock cycles after `por_n` rises, and none of the three events affects it.
- R9: PLL register bit 0 reads the synchronized lock input. Bit 1 is set when the block has waited LOCK_MAX_US×CLK_MHZ cycles for lock without getting it. Bit 1 is sticky and is cleared by writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| wdog_ovf | input | 1 | Watchdog overflow, synchronous to clk |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data, combinational from reg_addr |
| sys_rst_n | output | 1 | Main chip reset, active low |
| iso_rst_n | output | 1 | Reset for the excluded subsystem, active low |

## Verification
The hardest situation to reach is the one where the chip is already in reset and the release is held back for several reasons at once. In that state several sources overlap, the PLL is unlocked long enough for the late flag to set, and software tries a request that must be discarded. The stimulus gets there in stages. It first drops `pll_lock` so that an otherwise brief software or watchdog reset stays visible. It then holds the pin low across a watchdog burst, and it writes the request bit while the pin still holds the reset. Finally it reads back the cause and PLL registers to confirm that every overlapping source was recorded and nothing extra was.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [1:0] {
    SQ_RUN      = 2'd0,
    SQ_HOLD     = 2'd1,
    SQ_LOCKWAIT = 2'd2
  } seq_state_e;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_CAUSE = 1;
  localparam int ADDR_PLL   = 2;

  localparam int CAUSE_PIN = 0;
  localparam int CAUSE_SW  = 1;
  localparam int CAUSE_WD  = 2;
  localparam int NCAUSE    = 3;

  function automatic int us_to_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  function automatic int cnt_width(input int limit);
    int w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= {W{RST_VAL}};
      out_q  <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      out_q  <= meta_q;
    end
  end

  assign q = out_q;
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int MIN_CYC = 1750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_s,
  output logic hw_evt
);
  localparam int           CW  = rstc_pkg::cnt_width(MIN_CYC);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (pin_n_s)       run_q <= '0;
    else if (run_q != LIM)  run_q <= run_q + 1'b1;
  end

  assign hw_evt = (run_q == LIM);
endmodule

// File: rtl/rstc_sequencer.sv
module rstc_sequencer #(
  parameter int LOCK_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_src,
  input  logic lock_s,
  output logic sys_rst_n,
  output logic rst_active,
  output logic lock_late
);
  import rstc_pkg::*;

  localparam int            CW  = cnt_width(LOCK_CYC);
  localparam logic [CW-1:0] LIM = CW'(LOCK_CYC);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] wait_q;
  logic          out_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_RUN:      if (any_src) state_d = SQ_HOLD;
      SQ_HOLD:     if (!any_src) state_d = SQ_LOCKWAIT;
      SQ_LOCKWAIT: begin
        if (any_src)     state_d = SQ_HOLD;
        else if (lock_s) state_d = SQ_RUN;
      end
      default:     state_d = SQ_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_LOCKWAIT;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      out_q   <= (state_d == SQ_RUN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        wait_q <= '0;
    else if (state_q != SQ_LOCKWAIT)   wait_q <= '0;
    else if (wait_q != LIM)            wait_q <= wait_q + 1'b1;
  end

  assign sys_rst_n  = out_q;
  assign rst_active = (state_q != SQ_RUN);
  assign lock_late  = (state_q == SQ_LOCKWAIT) && (wait_q == LIM) && !lock_s;
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs #(
  parameter int AW = 2,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  input  logic          hw_evt,
  input  logic          wd_evt,
  input  logic          rst_active,
  input  logic          lock_s,
  input  logic          lock_late,
  output logic          sw_pend,
  output logic [rstc_pkg::NCAUSE-1:0] cause
);
  import rstc_pkg::*;

  logic              pend_q;
  logic [NCAUSE-1:0] cause_q, cause_set, cause_clr;
  logic              late_q;
  logic              wr_ctrl, wr_cause, wr_pll;
  logic              unused_wdata;

  assign wr_ctrl  = we && (addr == AW'(ADDR_CTRL));
  assign wr_cause = we && (addr == AW'(ADDR_CAUSE));
  assign wr_pll   = we && (addr == AW'(ADDR_PLL));
  assign unused_wdata = ^wdata[RW-1:NCAUSE];

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_PIN] = hw_evt;
    cause_set[CAUSE_SW]  = pend_q;
    cause_set[CAUSE_WD]  = wd_evt;
    cause_clr            = wr_cause ? wdata[NCAUSE-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cause_q <= '0;
      late_q  <= 1'b0;
    end else begin
      if (rst_active)                pend_q <= 1'b0;
      else if (wr_ctrl && wdata[0])  pend_q <= 1'b1;
      cause_q <= (cause_q & ~cause_clr) | cause_set;
      if (lock_late)                 late_q <= 1'b1;
      else if (wr_pll && wdata[1])   late_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CTRL))       rdata[0] = pend_q;
    else if (addr == AW'(ADDR_CAUSE)) rdata[NCAUSE-1:0] = cause_q;
    else if (addr == AW'(ADDR_PLL))   rdata[1:0] = {late_q, lock_s};
  end

  assign sw_pend = pend_q;
  assign cause   = cause_q;
endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl #(
  parameter int CLK_MHZ     = 50,
  parameter int PIN_MIN_US  = 35,
  parameter int LOCK_MAX_US = 400,
  parameter int AW          = 2,
  parameter int RW          = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ext_rst_n,
  input  logic          wdog_ovf,
  input  logic          pll_lock,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          sys_rst_n,
  output logic          iso_rst_n
);
  import rstc_pkg::*;

  localparam int PIN_CYC  = us_to_cycles(CLK_MHZ, PIN_MIN_US);
  localparam int LOCK_CYC = us_to_cycles(CLK_MHZ, LOCK_MAX_US);

  logic              ctl_rst_n;
  logic              pin_s;
  logic              lock_s;
  logic              hw_evt;
  logic              sw_pend;
  logic              any_src;
  logic              rst_active;
  logic              lock_late;
  logic [NCAUSE-1:0] cause_bits;

  rstc_sync #(.W(1), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(ctl_rst_n)
  );

  rstc_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(ctl_rst_n), .d(ext_rst_n), .q(pin_s)
  );

  rstc_sync #(.W(1), .RST_VAL(1'b0)) u_lock_sync (
    .clk(clk), .arst_n(ctl_rst_n), .d(pll_lock), .q(lock_s)
  );

  rstc_pin_filter #(.MIN_CYC(PIN_CYC)) u_filter (
    .clk(clk), .rst_n(ctl_rst_n), .pin_n_s(pin_s), .hw_evt(hw_evt)
  );

  assign any_src = hw_evt | sw_pend | wdog_ovf;

  rstc_sequencer #(.LOCK_CYC(LOCK_CYC)) u_seq (
    .clk(clk), .rst_n(ctl_rst_n), .any_src(any_src), .lock_s(lock_s),
    .sys_rst_n(sys_rst_n), .rst_active(rst_active), .lock_late(lock_late)
  );

  rstc_regs #(.AW(AW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(ctl_rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .hw_evt(hw_evt), .wd_evt(wdog_ovf),
    .rst_active(rst_active), .lock_s(lock_s), .lock_late(lock_late),
    .sw_pend(sw_pend), .cause(cause_bits)
  );

  assign iso_rst_n = ctl_rst_n;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter int AW      = 2,
  parameter int MIN_CYC = 1750
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sys_rst_n,
  input logic          iso_rst_n,
  input logic          any_src,
  input logic          lock_s,
  input logic          rst_active,
  input logic          sw_pend,
  input logic          pin_s,
  input logic          hw_evt,
  input logic          wdog_ovf,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [2:0]    cause
);
  localparam int            CW  = rstc_pkg::cnt_width(MIN_CYC);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

  logic [CW-1:0] low_q;
  logic          cause_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_q <= '0;
    else if (pin_s)        low_q <= '0;
    else if (low_q != LIM) low_q <= low_q + 1'b1;
  end

  assign cause_wr = reg_we && (reg_addr == AW'(rstc_pkg::ADDR_CAUSE));

  AST_RELEASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(lock_s)); // R2
  AST_PIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |-> (low_q == LIM)); // R3
  AST_SW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> !sw_pend); // R4
  AST_WD_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_ovf |=> cause[2]); // R5
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> ((cause & $past(cause)) == $past(cause))); // R6
  AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> !sys_rst_n); // R7
  AST_ISO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    iso_rst_n |=> iso_rst_n); // R8
endmodule

bind sys_reset_ctrl rstc_checker #(.AW(AW), .MIN_CYC(PIN_CYC)) u_chk (
  .clk(clk), .rst_n(ctl_rst_n), .sys_rst_n(sys_rst_n), .iso_rst_n(iso_rst_n),
  .any_src(any_src), .lock_s(lock_s), .rst_active(rst_active),
  .sw_pend(sw_pend), .pin_s(pin_s), .hw_evt(hw_evt), .wdog_ovf(wdog_ovf),
  .reg_we(reg_we), .reg_addr(reg_addr), .cause(cause_bits)
);

// File: tb/sim_sys_reset_ctrl.sv
module sim_sys_reset_ctrl;
  localparam int AW = 2;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          ext_rst_n = 1'b1;
  logic          wdog_ovf = 1'b0;
  logic          pll_lock = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          sys_rst_n;
  logic          iso_rst_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    int    kind;
    int    addr;
    int    exp;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  sys_reset_ctrl #(.CLK_MHZ(1), .PIN_MIN_US(20), .LOCK_MAX_US(50),
                   .AW(AW), .RW(RW)) u0 (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdog_ovf(wdog_ovf),
    .pll_lock(pll_lock), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_n(sys_rst_n), .iso_rst_n(iso_rst_n)
  );

  // monitor: kind 0 = sys_rst_n, 1 = iso_rst_n, 2 = register read
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t it;
        int act;
        it = sb_q.pop_front();
        if (it.kind == 2) reg_addr = AW'(it.addr);
        #1;
        case (it.kind)
          0:       act = int'(sys_rst_n);
          1:       act = int'(iso_rst_n);
          default: act = int'(reg_rdata);
        endcase
        n_cmp++;
        if (act != it.exp) begin
          n_bad++;
          $display("FAIL %s: got %0h expected %0h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input int addr, input int exp,
                             input string req);
    exp_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #2;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(addr); reg_wdata = RW'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: power-on state
    cyc(3);
    expect_item(0, 0, 0, "R1 sys during por");
    expect_item(1, 0, 0, "R1 iso during por");
    por_n = 1'b1;
    cyc(20);
    expect_item(1, 0, 1, "R8 iso released after por");
    expect_item(0, 0, 0, "R2 sys held while unlocked");
    expect_item(2, 1, 0, "R1 cause zero");
    expect_item(2, 2, 0, "R1 pll reg zero");
    pll_lock = 1'b1;
    cyc(6);
    expect_item(0, 0, 1, "R2 sys released on lock");
    expect_item(2, 2, 1, "R9 lock bit");

    // R3: short pulse ignored
    ext_rst_n = 1'b0; cyc(8); ext_rst_n = 1'b1;
    cyc(30);
    expect_item(0, 0, 1, "R3 short pulse no reset");
    expect_item(2, 1, 0, "R3 short pulse no cause");

    // R3: long pulse accepted
    ext_rst_n = 1'b0; cyc(30);
    expect_item(0, 0, 0, "R3 long pulse resets");
    expect_item(1, 0, 1, "R8 iso unaffected by pin");
    ext_rst_n = 1'b1; cyc(10);
    expect_item(0, 0, 1, "R2 release after pin");
    expect_item(2, 1, 1, "R6 pin cause kept");

    // R6: write-one-to-clear
    wr(1, 0); cyc(1);
    expect_item(2, 1, 1, "R6 write 0 keeps");
    wr(1, 1); cyc(1);
    expect_item(2, 1, 0, "R6 write 1 clears");

    // R4: software request
    pll_lock = 1'b0; cyc(4);
    wr(0, 1); cyc(10);
    expect_item(0, 0, 0, "R4 sw reset");
    expect_item(2, 0, 0, "R4 request self-cleared");
    expect_item(2, 1, 2, "R4 sw cause");
    expect_item(1, 0, 1, "R8 iso unaffected by sw");
    pll_lock = 1'b1; cyc(8);
    expect_item(0, 0, 1, "R2 release after sw");
    wr(1, 7); cyc(1);

    // R5 and R9: watchdog with slow lock
    pll_lock = 1'b0; cyc(4);
    @(negedge clk); wdog_ovf = 1'b1; @(negedge clk); wdog_ovf = 1'b0;
    cyc(10);
    expect_item(0, 0, 0, "R5 watchdog resets");
    expect_item(2, 1, 4, "R5 watchdog cause");
    expect_item(2, 2, 0, "R9 not late yet");
    cyc(60);
    expect_item(2, 2, 2, "R9 late flag set");
    pll_lock = 1'b1; cyc(8);
    expect_item(0, 0, 1, "R2 release after late lock");
    expect_item(2, 2, 3, "R9 late sticky");
    wr(2, 2); cyc(1);
    expect_item(2, 2, 1, "R9 late cleared");
    wr(1, 7); cyc(1);

    // R7: overlapping pin and watchdog, sw write discarded
    ext_rst_n = 1'b0; wdog_ovf = 1'b1;
    cyc(30);
    expect_item(0, 0, 0, "R7 overlap resets");
    wdog_ovf = 1'b0;
    wr(0, 1);
    cyc(10);
    expect_item(0, 0, 0, "R7 pin still holds");
    expect_item(2, 0, 0, "R4 write during reset dropped");
    ext_rst_n = 1'b1; cyc(10);
    expect_item(0, 0, 1, "R7 release after last source");
    expect_item(2, 1, 5, "R7 both causes");

    // R1: power-on during operation
    @(negedge clk); por_n = 1'b0; #1;
    expect_item(0, 0, 0, "R1 async sys on por");
    expect_item(1, 0, 0, "R1 async iso on por");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule